// File: doc/BRIEF.md
# Complementary Output Stage with Dead-Time

This block sits between two PWM generators and a high-side/low-side switch pair. In independent mode it registers the two generator signals onto the two drive outputs, one each. In complementary mode it takes one generator, chosen by a source-select bit, and drives the high output with that signal and the low output with its inverse. The other generator has no effect.

In complementary mode, every level change of the selected source loads a programmable down-counter. Both drives stay low until the counter has run out, so the pair is never on at the same time. The output that is turning off drops at once. The output that is turning on waits out the programmed dead time. A change of mode, or of source while in complementary mode, also loads the counter, so the switch pair gets the same guard interval when it is reconfigured.

Top module: `pwm_deadtime_stage`

## Requirements
- R1: With `comp_mode_i`=0 and no guard interval pending, `drv_hi_o` equals `pwm_a_i` and `drv_lo_o` equals `pwm_b_i` as sampled at the previous rising clock edge. No dead time is inserted for edges on either input.
- R2: While `rst` is high, both drive outputs are 0 and the stage returns to independent mode with source A selected and no guard pending.
- R3: With `comp_mode_i`=1 and `src_sel_i`=0, source A is the selected source. Once settled, `drv_hi_o` equals the sampled A level and `drv_lo_o` equals its inverse. `pwm_b_i` has no effect on either output.
- R4: With `comp_mode_i`=1 and `src_sel_i`=1, source B is the selected source, in the same way as R3. `pwm_a_i` has no effect on either output.
- R5: In complementary mode, `drv_hi_o` and `drv_lo_o` are never both 1.
- R6: Suppose the selected source is sampled at clock edge k with a different level than at edge k-1, and the dead-time value at edge k is D. Then both outputs are 0 after edges k through k+D. After edge k+D+1 the output matching the new level is 1. For a rising edge that output is `drv_hi_o`.
- R7: A falling edge of the selected source follows the same timing as R6. `drv_hi_o` drops after edge k, and `drv_lo_o` turns on after edge k+D+1.
- R8: With a dead-time value of 0, an edge of the selected source gives exactly one cycle with both outputs 0.
- R9: A new edge of the selected source that arrives while the counter is still running reloads the counter with the current dead-time value. Both outputs stay 0 until the reloaded count has expired.
- R10: A change of `comp_mode_i` in either direction, or a change of `src_sel_i` while `comp_mode_i`=1, forces both outputs to 0 for D+1 cycles. D is the dead-time value sampled at the edge where the change is seen. The outputs of the new configuration are driven after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pwm_a_i | input | 1 | PWM signal from generator A |
| pwm_b_i | input | 1 | PWM signal from generator B |
| comp_mode_i | input | 1 | 0 = independent, 1 = complementary |
| src_sel_i | input | 1 | Complementary source: 0 = A, 1 = B |
| dead_cnt_i | input | DT_W (8) | Dead-time length in clock cycles |
| drv_hi_o | output | 1 | High-side drive |
| drv_lo_o | output | 1 | Low-side drive |

## Verification
The hardest case to reach from the ports is a retrigger: a second edge of the selected source that lands while the guard counter is still running. A reconfiguration landing in the middle of a guard interval is similarly hard. The stimulus reaches both by setting a long dead time and toggling the selected source every two cycles. It then switches mode and source during a running guard interval. Dead-time and source sequences are also randomised in complementary mode, while the unselected generator toggles freely. This shows both that the pair never overlaps and that the ignored input never leaks through.

// File: rtl/dts_pkg.sv
package dts_pkg;
  typedef enum logic {
    MODE_INDEP = 1'b0,
    MODE_COMP  = 1'b1
  } drive_mode_e;

  typedef struct packed {
    drive_mode_e mode;
    logic        src;
  } drive_cfg_t;
endpackage

// File: rtl/dts_src_select.sv
module dts_src_select
  import dts_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic pwm_a_i,
  input  logic pwm_b_i,
  input  logic comp_mode_i,
  input  logic src_sel_i,
  output logic sel_lvl_o,
  output logic edge_o,
  output logic cfg_chg_o
);
  logic       prev_q;
  drive_cfg_t cfg_now;
  drive_cfg_t cfg_q;

  assign cfg_now.mode = drive_mode_e'(comp_mode_i);
  assign cfg_now.src  = src_sel_i;
  assign sel_lvl_o    = src_sel_i ? pwm_b_i : pwm_a_i;

  // Edges only matter while the pair is complementary.
  assign edge_o    = (cfg_now.mode == MODE_COMP) && (sel_lvl_o != prev_q);
  assign cfg_chg_o = (cfg_now.mode != cfg_q.mode) ||
                     ((cfg_now.mode == MODE_COMP) && (cfg_now.src != cfg_q.src));

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      cfg_q  <= '{mode: MODE_INDEP, src: 1'b0};
    end else begin
      prev_q <= sel_lvl_o;
      cfg_q  <= cfg_now;
    end
  end

  AST_EDGE_ONLY_COMP: assert property (@(posedge clk) disable iff (rst)
    !comp_mode_i |-> !edge_o); // R1
endmodule

// File: rtl/dts_hold_timer.sv
module dts_hold_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         busy_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load_i)       cnt_q <= load_val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - ONE;
  end

  assign busy_o = (cnt_q != '0);

  AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (cnt_q == $past(load_val_i))); // R9
  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
    (!load_i && busy_o) |=> (cnt_q == $past(cnt_q) - ONE)); // R6
  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !busy_o) |=> !busy_o); // R8
endmodule

// File: rtl/pwm_deadtime_stage.sv
module pwm_deadtime_stage #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pwm_a_i,
  input  logic            pwm_b_i,
  input  logic            comp_mode_i,
  input  logic            src_sel_i,
  input  logic [DT_W-1:0] dead_cnt_i,
  output logic            drv_hi_o,
  output logic            drv_lo_o
);
  logic sel_lvl;
  logic src_edge;
  logic cfg_chg;
  logic guard_load;
  logic guard_busy;

  dts_src_select u_sel (
    .clk         (clk),
    .rst         (rst),
    .pwm_a_i     (pwm_a_i),
    .pwm_b_i     (pwm_b_i),
    .comp_mode_i (comp_mode_i),
    .src_sel_i   (src_sel_i),
    .sel_lvl_o   (sel_lvl),
    .edge_o      (src_edge),
    .cfg_chg_o   (cfg_chg)
  );

  assign guard_load = src_edge | cfg_chg;

  dts_hold_timer #(.W(DT_W)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .load_i     (guard_load),
    .load_val_i (dead_cnt_i),
    .busy_o     (guard_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_hi_o <= 1'b0;
      drv_lo_o <= 1'b0;
    end else if (guard_load || guard_busy) begin
      drv_hi_o <= 1'b0;
      drv_lo_o <= 1'b0;
    end else if (comp_mode_i) begin
      drv_hi_o <= sel_lvl;
      drv_lo_o <= ~sel_lvl;
    end else begin
      drv_hi_o <= pwm_a_i;
      drv_lo_o <= pwm_b_i;
    end
  end

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    $past(comp_mode_i) |-> !(drv_hi_o && drv_lo_o)); // R5
  AST_GUARD_LOW: assert property (@(posedge clk) disable iff (rst)
    (guard_load || guard_busy) |=> (!drv_hi_o && !drv_lo_o)); // R10
  AST_IND_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (!comp_mode_i && !guard_load && !guard_busy)
      |=> (drv_hi_o == $past(pwm_a_i) && drv_lo_o == $past(pwm_b_i))); // R1
  AST_SRC_A: assert property (@(posedge clk) disable iff (rst)
    (comp_mode_i && !src_sel_i && !guard_load && !guard_busy)
      |=> (drv_hi_o == $past(pwm_a_i) && drv_lo_o != $past(pwm_a_i))); // R3
  AST_SRC_B: assert property (@(posedge clk) disable iff (rst)
    (comp_mode_i && src_sel_i && !guard_load && !guard_busy)
      |=> (drv_hi_o == $past(pwm_b_i) && drv_lo_o != $past(pwm_b_i))); // R4
endmodule

// File: tb/tb_pwm_deadtime_stage.sv
module tb_pwm_deadtime_stage;
  localparam int DT_W = 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            pwm_a = 1'b0;
  logic            pwm_b = 1'b0;
  logic            comp = 1'b0;
  logic            src = 1'b0;
  logic [DT_W-1:0] dt = '0;
  logic            hi;
  logic            lo;

  pwm_deadtime_stage #(.DT_W(DT_W)) dut (
    .clk (clk), .rst (rst), .pwm_a_i (pwm_a), .pwm_b_i (pwm_b),
    .comp_mode_i (comp), .src_sel_i (src), .dead_cnt_i (dt),
    .drv_hi_o (hi), .drv_lo_o (lo)
  );

  always #2 clk = ~clk;

  typedef struct {
    logic  hi;
    logic  lo;
    logic  comp;
    string tag;
  } exp_t;

  exp_t q[$];
  int   n_vec  = 0;
  int   n_fail = 0;

  // Reference state, reset values as per R2.
  logic m_prev = 1'b0;
  logic m_mode = 1'b0;
  logic m_src  = 1'b0;
  int   m_hold = 0;

  task automatic step(input logic a, input logic b, input logic md,
                      input logic s, input int d, input string tag);
    logic sel, chg, edg;
    exp_t e;
    @(negedge clk);
    pwm_a = a; pwm_b = b; comp = md; src = s; dt = DT_W'(d);
    sel = s ? b : a;
    chg = (md != m_mode) || (md && (s != m_src));
    edg = md && (sel != m_prev);
    if (chg || edg) begin
      m_hold = d; e.hi = 1'b0; e.lo = 1'b0;
    end else if (m_hold > 0) begin
      m_hold--;  e.hi = 1'b0; e.lo = 1'b0;
    end else if (md) begin
      e.hi = sel; e.lo = ~sel;
    end else begin
      e.hi = a;   e.lo = b;
    end
    e.comp = md;
    e.tag  = tag;
    m_prev = sel; m_mode = md; m_src = s;
    q.push_back(e);
  endtask

  // Monitor: compare one item per clock, sampled 1 ns after the edge.
  always begin
    exp_t e;
    @(posedge clk);
    #1;
    if (q.size() > 0) begin
      e = q.pop_front();
      n_vec++;
      if (hi !== e.hi || lo !== e.lo) begin
        n_fail++;
        $display("FAIL %s: hi/lo=%b%b expected %b%b at %0t", e.tag, hi, lo, e.hi, e.lo, $time);
      end
      if (e.comp && hi === 1'b1 && lo === 1'b1) begin
        n_fail++;
        $display("FAIL R5: hi/lo=11 expected not both high at %0t", $time);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_vec++;
    if (hi !== 1'b0 || lo !== 1'b0) begin
      n_fail++;
      $display("FAIL R2: hi/lo=%b%b expected 00", hi, lo);
    end
    rst = 1'b0;

    // R2 + R1: independent mode straight out of reset
    step(1, 0, 0, 0, 5, "R2");
    for (int i = 0; i < 24; i++)
      step(1'($urandom), 1'($urandom), 0, 0, 9, "R1");

    // R3: complementary on A, B toggling freely, dead time 3
    for (int i = 0; i < 40; i++)
      step(1'((i / 8) % 2), 1'($urandom), 1, 0, 3, "R3");
    // R6 / R7 explicit rise and fall on A with D=4
    for (int i = 0; i < 12; i++) step(1, 1'($urandom), 1, 0, 4, "R6");
    for (int i = 0; i < 12; i++) step(0, 1'($urandom), 1, 0, 4, "R7");

    // R4: switch to source B, A toggling freely, dead time 2
    for (int i = 0; i < 40; i++)
      step(1'($urandom), 1'((i / 6) % 2), 1, 1, 2, "R4");

    // R8: zero dead time
    for (int i = 0; i < 30; i++)
      step(1'($urandom), 1'((i / 3) % 2), 1, 1, 0, "R8");

    // R9: retrigger with D=5, source toggling every two cycles
    for (int i = 0; i < 20; i++)
      step(1'($urandom), 1'((i / 2) % 2), 1, 1, 5, "R9");
    for (int i = 0; i < 10; i++) step(0, 1, 1, 1, 5, "R9");

    // R10: reconfiguration, also mid-guard
    for (int i = 0; i < 10; i++) step(1, 0, 1, 0, 6, "R10");
    for (int i = 0; i < 3;  i++) step(1, 0, 1, 1, 6, "R10");
    for (int i = 0; i < 10; i++) step(1, 0, 0, 1, 3, "R10");
    for (int i = 0; i < 10; i++) step(1, 1, 1, 1, 3, "R10");
    for (int i = 0; i < 6;  i++) step(0, 1, 0, 0, 2, "R10");

    // R5: long random complementary run
    for (int i = 0; i < 300; i++)
      step(1'($urandom), 1'($urandom), 1, 1'(($urandom % 16) == 0),
           int'($urandom % 4), "R5");

    repeat (3) @(posedge clk);
    #2;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule